// File: doc/BRIEF.md
# PRD Scatter-Gather DMA Engine

The engine copies bytes between a local device buffer and scattered regions of system memory. The regions are listed in a descriptor table in memory. Each descriptor is eight bytes long and names a region address and a byte count. The engine reads a descriptor only when the one it is working on has no bytes left. It decodes the byte count and moves data one byte per memory access, in bursts. The burst size is set by the buffer bytes still to move, the bytes left in the descriptor, and a beat cap.

A controller drives the engine through a few pulses, all honoured only while the engine is idle. One pulse reloads the table pointer from a base address. One pulse clears the current descriptor. One pulse starts a buffer pass, giving the first buffer index, the buffer size and the direction. A pass ends with one of two one-cycle pulses. The first says the buffer was fully consumed. The second says the table ran out, either because the final descriptor was used up or because the pointer moved a full page past the base. The descriptor state carries over between passes, so one descriptor can serve several buffer refills.

Top module: `prd_sg_engine`

## Requirements
- R1: After reset the engine is idle: `busy`, `df_valid`, `mem_valid`, `buf_we`, `buf_done` and `tbl_exhausted` are all low.
- R2: Descriptors are read at the table pointer, which advances by 8 after each read. The returned 64-bit word holds the region address in bits 31:0 and the control word in bits 63:32.
- R3: The descriptor byte count is control bits 15:0 with bit 0 cleared. A count of zero means 65536 bytes.
- R4: A descriptor is read only when the current descriptor has zero bytes left. While bytes remain, a new pass continues at the next region address without reading the table.
- R5: When the current descriptor has zero bytes left, buffer bytes remain, and the current descriptor had control bit 31 (final) set, the engine pulses `tbl_exhausted` and reads nothing.
- R6: When the current descriptor has zero bytes left, buffer bytes remain, and the pointer is PAGE_BYTES or more past the base, the engine pulses `tbl_exhausted` and does not read the table.
- R7: Data moves as single-byte accesses to consecutive region addresses. A pass makes min(buffer bytes left, descriptor bytes left) accesses per descriptor. Each burst holds at most MAX_BEATS accesses.
- R8: With `dir_to_mem`=1, each access writes (`mem_we`=1) the buffer byte at the current index. With `dir_to_mem`=0, each acknowledged read byte is written into the buffer at the current index.
- R9: When the buffer index reaches `buf_size`, the engine pulses `buf_done`, which is never high together with `tbl_exhausted`. A `buf_done` pulse takes priority over a table check.
- R10: `ptr_reload` loads the table pointer and base from `tbl_base`. `desc_clear` zeroes the current descriptor's address, count and final flag, so the next pass reads the table.
- R11: A request on either master port stays asserted with a stable address until it is accepted by `*_ready`. Data or read data returns with a later `*_ack`.
- R12: `ptr_reload`, `desc_clear` and `run` have no effect while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbl_base | input | AW | Descriptor table base address |
| ptr_reload | input | 1 | Load table pointer and base from `tbl_base` |
| desc_clear | input | 1 | Clear current descriptor state |
| run | input | 1 | Start a buffer pass |
| dir_to_mem | input | 1 | 1: buffer to memory, 0: memory to buffer |
| buf_first | input | BUF_AW+1 | First buffer index of the pass |
| buf_size | input | BUF_AW+1 | Buffer end index (bytes) |
| busy | output | 1 | Pass in progress |
| buf_done | output | 1 | Pulse: buffer consumed |
| tbl_exhausted | output | 1 | Pulse: table ran out |
| df_valid | output | 1 | Descriptor read request |
| df_ready | input | 1 | Descriptor request accepted |
| df_addr | output | AW | Descriptor address |
| df_ack | input | 1 | Descriptor data valid |
| df_rdata | input | 64 | Descriptor data |
| mem_valid | output | 1 | Data access request |
| mem_ready | input | 1 | Data request accepted |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Data byte address |
| mem_wdata | output | 8 | Write byte |
| mem_ack | input | 1 | Access complete |
| mem_rdata | input | 8 | Read byte |
| buf_raddr | output | BUF_AW | Buffer read address (one-cycle latency) |
| buf_rdata | input | 8 | Buffer read data |
| buf_we | output | 1 | Buffer write enable |
| buf_waddr | output | BUF_AW | Buffer write address |
| buf_wdata | output | 8 | Buffer write data |

## Verification
The assertions check, on every cycle, the local rules of the engine. Requests hold steady until accepted, and the two master ports are never active together. No descriptor is read while bytes remain. The decoded count never exceeds 65536, and no burst exceeds the beat cap. Buffer writes stay below the end index, and the two outcome pulses never coincide. The bench scenarios show the behaviours that span a whole pass or several passes. These are the access sequence and byte values in both directions, and a descriptor carried across refills. They also cover the end-of-table and one-page stops, the zero-means-64-KiB decode, and control pulses dropped while the engine is busy.

// File: rtl/prd_sg_engine.sv
module prd_sg_engine #(
  parameter int AW         = 32,
  parameter int BUF_AW     = 8,
  parameter int MAX_BEATS  = 4,
  parameter int PAGE_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     tbl_base,
  input  logic              ptr_reload,
  input  logic              desc_clear,
  input  logic              run,
  input  logic              dir_to_mem,
  input  logic [BUF_AW:0]   buf_first,
  input  logic [BUF_AW:0]   buf_size,
  output logic              busy,
  output logic              buf_done,
  output logic              tbl_exhausted,
  output logic              df_valid,
  input  logic              df_ready,
  output logic [AW-1:0]     df_addr,
  input  logic              df_ack,
  input  logic [63:0]       df_rdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic              mem_ack,
  input  logic [7:0]        mem_rdata,
  output logic [BUF_AW-1:0] buf_raddr,
  input  logic [7:0]        buf_rdata,
  output logic              buf_we,
  output logic [BUF_AW-1:0] buf_waddr,
  output logic [7:0]        buf_wdata
);
  localparam int LW = 17;
  localparam int BW = $clog2(MAX_BEATS + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_FREQ, S_FWAIT, S_PREP, S_MREQ, S_MWAIT
  } st_t;

  st_t             st;
  logic [AW-1:0]   base_r, fptr, cur_addr;
  logic [LW-1:0]   cur_len;
  logic            cur_last;
  logic [BUF_AW:0] idx, end_r;
  logic            dir_r;
  logic [BW-1:0]   bcnt;

  logic            left_zero, page_hit;
  logic [LW-1:0]   left_w, m1;
  logic [BW-1:0]   burst_n;
  logic [15:0]     dec16;
  logic [LW-1:0]   new_len;
  logic            unused_bits;

  assign left_zero = (idx >= end_r);
  assign left_w    = LW'(end_r - idx);
  assign m1        = (left_w < cur_len) ? left_w : cur_len;
  assign burst_n   = (m1 > LW'(MAX_BEATS)) ? BW'(MAX_BEATS) : BW'(m1);
  assign page_hit  = ((fptr - base_r) >= AW'(PAGE_BYTES));
  assign dec16     = {df_rdata[47:33], 1'b0};
  assign new_len   = (dec16 == 16'd0) ? 17'h10000 : {1'b0, dec16};
  assign unused_bits = ^{df_rdata[62:48], df_rdata[32]};

  assign busy      = (st != S_IDLE);
  assign df_valid  = (st == S_FREQ);
  assign df_addr   = fptr;
  assign mem_valid = (st == S_MREQ);
  assign mem_we    = dir_r;
  assign mem_addr  = cur_addr;
  assign mem_wdata = buf_rdata;
  assign buf_raddr = idx[BUF_AW-1:0];
  assign buf_we    = (st == S_MWAIT) && mem_ack && !dir_r;
  assign buf_waddr = idx[BUF_AW-1:0];
  assign buf_wdata = mem_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      base_r <= '0;
      fptr <= '0;
      cur_addr <= '0;
      cur_len <= '0;
      cur_last <= 1'b0;
      idx <= '0;
      end_r <= '0;
      dir_r <= 1'b0;
      bcnt <= '0;
      buf_done <= 1'b0;
      tbl_exhausted <= 1'b0;
    end else begin
      buf_done <= 1'b0;
      tbl_exhausted <= 1'b0;
      case (st)
        S_IDLE: begin
          if (ptr_reload) begin
            base_r <= tbl_base;
            fptr <= tbl_base;
          end
          if (desc_clear) begin
            cur_addr <= '0;
            cur_len <= '0;
            cur_last <= 1'b0;
          end
          if (run) begin
            idx <= buf_first;
            end_r <= buf_size;
            dir_r <= dir_to_mem;
            st <= S_CHECK;
          end
        end
        S_CHECK: begin
          if (left_zero) begin
            buf_done <= 1'b1;
            st <= S_IDLE;
          end else if (cur_len == '0) begin
            if (cur_last || page_hit) begin
              tbl_exhausted <= 1'b1;
              st <= S_IDLE;
            end else begin
              st <= S_FREQ;
            end
          end else begin
            bcnt <= burst_n;
            st <= S_PREP;
          end
        end
        S_FREQ: if (df_ready) st <= S_FWAIT;
        S_FWAIT: begin
          if (df_ack) begin
            cur_addr <= df_rdata[AW-1:0];
            cur_len <= new_len;
            cur_last <= df_rdata[63];
            fptr <= fptr + AW'(8);
            st <= S_CHECK;
          end
        end
        S_PREP: st <= S_MREQ;
        S_MREQ: if (mem_ready) st <= S_MWAIT;
        S_MWAIT: begin
          if (mem_ack) begin
            cur_addr <= cur_addr + AW'(1);
            cur_len <= cur_len - LW'(1);
            idx <= idx + 1'b1;
            bcnt <= bcnt - 1'b1;
            st <= (bcnt == BW'(1)) ? S_CHECK : S_PREP;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r11_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we));
  a_r11_df_hold: assert property (@(posedge clk) disable iff (!rst_n)
    df_valid && !df_ready |=> df_valid && $stable(df_addr));
  a_r1_one_master: assert property (@(posedge clk) disable iff (!rst_n)
    !(df_valid && mem_valid));
  a_r4_lazy_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    df_valid |-> cur_len == '0);
  a_r3_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cur_len <= 17'h10000);
  a_r7_beat_cap: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> bcnt <= BW'(MAX_BEATS));
  a_r8_buf_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> ({1'b0, buf_waddr} < end_r));
  a_r9_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    !(buf_done && tbl_exhausted));
endmodule

// File: tb/prd_sg_engine_test.sv
module prd_sg_engine_test;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic [31:0] tbl_base = 0;
  logic ptr_reload = 0, desc_clear = 0, run = 0, dir_to_mem = 0;
  logic [8:0] buf_first = 0, buf_size = 0;
  logic busy, buf_done, tbl_exhausted;
  logic df_valid, df_ready, df_ack = 0;
  logic [31:0] df_addr;
  logic [63:0] df_rdata = 0;
  logic mem_valid, mem_ready, mem_we, mem_ack = 0;
  logic [31:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata = 0;
  logic [7:0] buf_raddr, buf_waddr, buf_wdata, buf_rdata = 0;
  logic buf_we;

  prd_sg_engine uut (.*);

  logic [63:0] dtab [64];
  logic ph = 0, stall = 0;
  int tests = 0, fails = 0;
  int mcnt = 0, fcnt = 0, bcnt = 0, holdbad = 0;
  logic [31:0] maddr [4096];
  logic [7:0]  mwd [4096];
  logic        mwe [4096];
  logic [31:0] faddr [1024];
  logic [7:0]  badr [512];
  logic [7:0]  bdat [512];
  logic pend_m = 0;
  logic [31:0] pend_a = 0;

  function automatic logic [7:0] pat(input int i); return 8'((i * 7 + 3) & 255); endfunction
  function automatic logic [7:0] dm(input logic [31:0] a); return a[7:0] ^ 8'h5A; endfunction

  assign mem_ready = mem_valid && (!stall || ph);
  assign df_ready  = df_valid && (!stall || ph);

  always @(posedge clk) begin
    ph <= ~ph;
    mem_ack <= mem_valid && mem_ready;
    df_ack  <= df_valid && df_ready;
    buf_rdata <= pat(int'(buf_raddr));
    if (mem_valid && mem_ready) begin
      maddr[mcnt] <= mem_addr; mwd[mcnt] <= mem_wdata; mwe[mcnt] <= mem_we;
      mem_rdata <= dm(mem_addr);
      mcnt <= mcnt + 1;
    end
    if (df_valid && df_ready) begin
      faddr[fcnt] <= df_addr;
      df_rdata <= dtab[df_addr[8:3]];
      fcnt <= fcnt + 1;
    end
    if (buf_we) begin
      badr[bcnt] <= buf_waddr; bdat[bcnt] <= buf_wdata; bcnt <= bcnt + 1;
    end
    if (pend_m && !(mem_valid && mem_addr == pend_a)) holdbad <= holdbad + 1;
    pend_m <= mem_valid && !mem_ready;
    pend_a <= mem_addr;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reload(input logic [31:0] b);
    @(negedge clk); tbl_base = b; ptr_reload = 1; desc_clear = 1;
    @(negedge clk); ptr_reload = 0; desc_clear = 0;
  endtask

  bit got_done, got_exh;
  int m0, f0, b0;

  task automatic pass(input int first, input int size, input bit dir, input bit poke);
    m0 = mcnt; f0 = fcnt; b0 = bcnt;
    @(negedge clk); buf_first = 9'(first); buf_size = 9'(size); dir_to_mem = dir; run = 1;
    @(negedge clk); run = 0;
    if (poke) begin
      repeat (2) @(negedge clk);
      tbl_base = 32'hF00; ptr_reload = 1; desc_clear = 1; run = 1;
      @(negedge clk); ptr_reload = 0; desc_clear = 0; run = 0;
    end
    while (!(buf_done || tbl_exhausted)) @(negedge clk);
    got_done = buf_done; got_exh = tbl_exhausted;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) dtab[i] = 64'h8000_0000_0000_0000;
    repeat (3) @(negedge clk);
    chk(!busy && !df_valid && !mem_valid && !buf_we && !buf_done && !tbl_exhausted,
        "R1 reset idle", {busy, df_valid, mem_valid, buf_done, tbl_exhausted}, 0);
    rst_n = 1;

    // T1: write direction, two descriptors, odd count rounded down
    dtab[32] = {32'h0000_000A, 32'h0000_0400};
    dtab[33] = {32'h8000_0007, 32'h0000_0800};
    reload(32'h100);
    stall = 1;
    pass(0, 16, 1, 0);
    chk(got_done, "R9 done after 16 bytes", got_done, 1);
    chk(fcnt - f0 == 2, "R2 two fetches", fcnt - f0, 2);
    chk(faddr[f0] == 32'h100 && faddr[f0+1] == 32'h108, "R2 fetch stride", faddr[f0+1], 32'h108);
    chk(mcnt - m0 == 16, "R3 10+6 bytes", mcnt - m0, 16);
    for (int k = 0; k < 16; k++) begin
      logic [31:0] ea;
      ea = (k < 10) ? 32'h400 + 32'(k) : 32'h800 + 32'(k - 10);
      chk(maddr[m0+k] == ea && mwe[m0+k] && mwd[m0+k] == pat(k), "R8 R7 write byte",
          {maddr[m0+k], mwd[m0+k]}, {ea, pat(k)});
    end
    chk(holdbad == 0, "R11 request held until ready", holdbad, 0);
    pass(0, 4, 1, 0);
    chk(got_exh && fcnt == f0 && mcnt == m0, "R5 final flag stops", {got_exh, 8'(fcnt - f0)}, 32'h100);

    // T2: read direction, descriptor spans passes, control ignored while busy
    stall = 0;
    dtab[0] = {32'h8000_0014, 32'h0000_0900};
    reload(32'h200);
    pass(0, 8, 0, 0);
    chk(got_done && fcnt - f0 == 1, "R4 one fetch pass1", fcnt - f0, 1);
    for (int k = 0; k < 8; k++)
      chk(badr[b0+k] == 8'(k) && bdat[b0+k] == dm(32'h900 + 32'(k)), "R8 read byte",
          {badr[b0+k], bdat[b0+k]}, {8'(k), dm(32'h900 + 32'(k))});
    pass(8, 16, 0, 1);
    chk(got_done && fcnt == f0, "R4 no fetch pass2", fcnt - f0, 0);
    chk(bcnt - b0 == 8 && badr[b0] == 8 && bdat[b0] == dm(32'h908), "R9 persist", bdat[b0], dm(32'h908));
    pass(0, 4, 0, 0);
    chk(got_done && fcnt == f0 && mcnt - m0 == 4, "R12 busy pulses ignored", fcnt - f0, 0);
    chk(maddr[m0] == 32'h910 && bdat[b0+3] == dm(32'h913), "R12 address continues", maddr[m0], 32'h910);
    pass(0, 4, 0, 0);
    chk(got_exh && fcnt == f0 && mcnt == m0, "R5 exhausted after span", got_exh, 1);

    // T3: zero count means 64 KiB
    dtab[32] = {32'h8000_0001, 32'h0000_0C00};
    reload(32'h300);
    pass(0, 32, 1, 0);
    chk(got_done && fcnt - f0 == 1 && mcnt - m0 == 32, "R3 zero len pass1", mcnt - m0, 32);
    pass(0, 32, 1, 0);
    chk(got_done && fcnt == f0 && maddr[m0] == 32'hC20 && maddr[m0+31] == 32'hC3F,
        "R3 zero len continues", maddr[m0], 32'hC20);
    reload(32'h300);
    pass(0, 2, 1, 0);
    chk(fcnt - f0 == 1 && faddr[f0] == 32'h300, "R10 reload and clear refetch", faddr[f0], 32'h300);

    // T5: sweep descriptor count against buffer size
    for (int L = 1; L <= 6; L++) begin
      for (int S = 1; S <= 12; S++) begin
        int exp_n;
        bit contig;
        dtab[56] = {32'h8000_0000 | 32'(2 * L), 32'h0000_0500};
        reload(32'h1C0);
        pass(0, S, 1, 0);
        exp_n = (S < 2 * L) ? S : 2 * L;
        contig = 1;
        for (int k = 0; k < exp_n; k++) if (maddr[m0+k] != 32'h500 + 32'(k)) contig = 0;
        chk(mcnt - m0 == exp_n && contig, "R7 burst count", mcnt - m0, exp_n);
        chk(got_done == (S <= 2 * L) && got_exh == (S > 2 * L), "R9 R5 outcome", got_done, S <= 2 * L);
      end
    end

    // T4: one-page fail-safe
    for (int i = 0; i < 64; i++) dtab[i] = {32'h0000_0002, 32'h0000_0A00};
    reload(32'h0);
    stall = 1;
    for (int p = 0; p < 4; p++) begin
      pass(0, 256, 1, 0);
      chk(got_done && fcnt - f0 == 128, "R6 page pass", fcnt - f0, 128);
    end
    pass(0, 2, 1, 0);
    chk(got_exh && fcnt == f0 && mcnt == m0, "R6 page fail-safe", {got_exh, 8'(fcnt - f0)}, 32'h100);
    chk(faddr[f0-1] == 32'hFF8, "R6 last fetch address", faddr[f0-1], 32'hFF8);
    chk(holdbad == 0, "R11 hold under stall", holdbad, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule